// File: doc/BRIEF.md
# Memory-Mapped Byte-Serial Packet Port

This block gives a host processor a small packet device behind a 64-byte register window. To send a frame, the host writes the frame length to the transmit count register. It then writes the payload one byte per access to the transmit data port. Once the number of bytes written matches the count, the block streams the frame out on a valid/ready/last byte interface and clears the count. Frames arriving on the receive byte stream are buffered. At the end of each frame the block loads the receive count with its length. The host then drains the frame one byte per read of the receive data port, and each read lowers the count by one.

An interrupt control register holds three sources: a transmit-done flag, a receive-ready flag and a self-test source. The block drives one level-sensitive interrupt line. While the receive-ready flag is set, no further frame is accepted from the line. The window also holds a fixed 64-bit identifier and a fixed interrupt routing value, both read-only. The identifier is an ASCII string stored with its first character in the least significant byte. Its last character is a version digit.

Top module: `pkt_port`

## Requirements
- R1: The identifier reads at offset 0x00 (bytes 0..3) and 0x04 (bytes 4..7). The first character of the signature is in the least significant byte, so the default "PKTPORT1" reads 0x50544B50 and 0x3154524F. Offset 0x18 returns the routing parameter (default 2). Writes to 0x00, 0x04, 0x08, 0x0C and 0x18 change nothing.
- R2: Offset 0x10 is the transmit count. A write sets it unless a frame is being sent, in which case the write is ignored. Each write to 0x20 stores bits 7:0 as the next payload byte. When the number of bytes stored equals the count, the frame goes out on tx_data in write order. tx_last is high only with the final byte, and payload writes made while sending are ignored.
- R3: In the cycle after the final transmit handshake, the transmit count reads 0 and interrupt control bit 0 (transmit done) reads 1.
- R4: While tx_valid is high and tx_ready is low, tx_valid, tx_data and tx_last hold their values.
- R5: A received frame loads the receive count at offset 0x0C with its length in bytes and sets interrupt control bit 1 (receive ready).
- R6: Each read of offset 0x1C returns the next received byte in bits 7:0, with the upper bits 0, and lowers the receive count by one. A read when the count is 0 returns 0 and changes nothing.
- R7: rx_ready is low while bit 1 is set or the receive count is nonzero. Bytes offered on the line during that time are not taken.
- R8: Writing 1 to interrupt control bit 0 or bit 1 clears that bit. Writing 0 to either bit leaves it unchanged.
- R9: Writing a word with bit 31 set raises a test interrupt, and bit 31 then reads 1. A read of interrupt control clears bit 31 but leaves the interrupt pending. A later write of all zeros removes the test interrupt.
- R10: irq is the OR of bit 0, bit 1 and the pending test interrupt. It stays high until every source is cleared.
- R11: Offset 0x08 bit 0 (busy) reads 1 while a frame is being sent, or while a received frame has begun but its last byte has not arrived. Otherwise it reads 0.
- R12: A transmit count larger than the buffer depth is stored as the depth. A received frame longer than the depth is cut to its first depth bytes, and its count equals the depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address within the window (bits 1:0 ignored) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| tx_valid | output | 1 | Transmit byte valid |
| tx_ready | input | 1 | Line accepts transmit byte |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Final byte of the frame |
| rx_valid | input | 1 | Receive byte valid |
| rx_ready | output | 1 | Block accepts receive byte |
| rx_data | input | 8 | Receive byte |
| rx_last | input | 1 | Final byte of the received frame |
| irq | output | 1 | Level interrupt |

## Verification
The bench targets the interrupt control register's three distinct write rules. A design that cleared bits on a write of 0, or dropped the test interrupt when bit 31 was read, would show a wrong irq level. It stalls the line during transmission, where a sender that advanced without ready would lose bytes. It also writes payload and the count while a frame is being sent, where a design that accepted those writes would corrupt the frame. On the receive side it reads the data port past the end of a frame and offers bytes while the receive-ready flag is set or unread data remains. A broken design there would underflow the count or overwrite the pending frame. Oversized counts and frames check the clamping to the buffer depth.

// File: rtl/pp_pkg.sv
// Package: shared register offsets, interrupt bit positions and helpers
// for the byte-serial packet port. Offsets are byte addresses in a
// 64-byte window; software decodes them, so they are fixed.
package pp_pkg;

    localparam logic [5:0] OFS_ID_LO = 6'h00;
    localparam logic [5:0] OFS_ID_HI = 6'h04;
    localparam logic [5:0] OFS_BUSY  = 6'h08;
    localparam logic [5:0] OFS_RXCNT = 6'h0C;
    localparam logic [5:0] OFS_TXCNT = 6'h10;
    localparam logic [5:0] OFS_ICTL  = 6'h14;
    localparam logic [5:0] OFS_ROUTE = 6'h18;
    localparam logic [5:0] OFS_RXDAT = 6'h1C;
    localparam logic [5:0] OFS_TXDAT = 6'h20;

    localparam int ICTL_TXDONE = 0;
    localparam int ICTL_RXRDY  = 1;
    localparam int ICTL_TEST   = 31;

    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_FILL = 2'd1,
        TX_SEND = 2'd2
    } tx_state_t;

    // Reverse byte order so the first string character lands in byte 0.
    function automatic logic [63:0] first_char_low(input logic [63:0] s);
        logic [63:0] r;
        for (int i = 0; i < 8; i++) begin
            r[8*i +: 8] = s[8*(7-i) +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/pp_tx_path.sv
// Transmit path: holds the host-written length, collects payload bytes
// into a buffer and streams the frame out once the byte total matches.
// Assumes CNT_W can hold DEPTH and DEPTH is a power of two.
module pp_tx_path #(
    parameter int DEPTH = 2048,
    parameter int CNT_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             len_we,
    input  logic [CNT_W-1:0] len_wdata,
    input  logic             byte_we,
    input  logic [7:0]       byte_wdata,
    input  logic             tx_ready,
    output logic             tx_valid,
    output logic [7:0]       tx_data,
    output logic             tx_last,
    output logic [CNT_W-1:0] len_q,
    output logic             done
);
    import pp_pkg::*;

    localparam int               AW      = $clog2(DEPTH);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] ONE_C   = CNT_W'(1);

    tx_state_t        state_q;
    logic [CNT_W-1:0] fill_q;
    logic [CNT_W-1:0] rd_q;
    logic [CNT_W-1:0] len_clamped;
    logic [7:0]       buf_mem [DEPTH];

    // Clamp the requested length to the buffer depth.
    always_comb len_clamped = (len_wdata > DEPTH_C) ? DEPTH_C : len_wdata;

    // Line-side outputs are driven only in the sending state.
    always_comb begin
        tx_valid = (state_q == TX_SEND);
        tx_data  = tx_valid ? buf_mem[rd_q[AW-1:0]] : 8'h00;
        tx_last  = tx_valid && (rd_q == len_q - ONE_C);
        done     = tx_valid && tx_ready && tx_last;
    end

    // Payload storage; written only while filling and below the length.
    always_ff @(posedge clk) begin
        if (state_q == TX_FILL && byte_we) begin
            buf_mem[fill_q[AW-1:0]] <= byte_wdata;
        end
    end

    // Length, fill counter, read index and state sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            fill_q  <= '0;
            rd_q    <= '0;
            len_q   <= '0;
        end else begin
            case (state_q)
                TX_IDLE, TX_FILL: begin
                    if (len_we) begin
                        len_q   <= len_clamped;
                        fill_q  <= '0;
                        state_q <= (len_clamped != '0) ? TX_FILL : TX_IDLE;
                    end else if (state_q == TX_FILL && byte_we) begin
                        fill_q <= fill_q + ONE_C;
                        if (fill_q + ONE_C == len_q) begin
                            state_q <= TX_SEND;
                            rd_q    <= '0;
                        end
                    end
                end
                TX_SEND: begin
                    if (tx_ready) begin
                        if (tx_last) begin
                            state_q <= TX_IDLE;
                            len_q   <= '0;
                            fill_q  <= '0;
                        end else begin
                            rd_q <= rd_q + ONE_C;
                        end
                    end
                end
                default: state_q <= TX_IDLE;
            endcase
        end
    end

    // The count reads zero right after the final handshake.
    assert_len_cleared_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && tx_last) |=> (len_q == '0));

    // A stalled byte is held unchanged until taken.
    assert_stall_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

endmodule

// File: rtl/pp_rx_path.sv
// Receive path: takes bytes from the line into a buffer, publishes the
// frame length as a count, and hands bytes to the host one per read.
// Assumes DEPTH is a power of two; excess bytes of long frames are dropped.
module pp_rx_path #(
    parameter int DEPTH = 2048,
    parameter int CNT_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic [7:0]       rx_data,
    input  logic             rx_last,
    input  logic             hold,
    input  logic             rd_pop,
    output logic             rx_ready,
    output logic [CNT_W-1:0] count_q,
    output logic [7:0]       rd_byte,
    output logic             receiving,
    output logic             done
);
    localparam int               AW      = $clog2(DEPTH);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] ONE_C   = CNT_W'(1);

    logic [CNT_W-1:0] fill_q;
    logic [CNT_W-1:0] fill_next;
    logic [CNT_W-1:0] rd_q;
    logic             take;
    logic             room;
    logic [7:0]       buf_mem [DEPTH];

    // Accept only when the previous frame is acknowledged and drained.
    always_comb begin
        rx_ready  = !hold && (count_q == '0);
        take      = rx_valid && rx_ready;
        room      = (fill_q < DEPTH_C);
        fill_next = room ? fill_q + ONE_C : fill_q;
        done      = take && rx_last;
        rd_byte   = (count_q != '0) ? buf_mem[rd_q[AW-1:0]] : 8'h00;
    end

    // Byte storage for the frame in progress.
    always_ff @(posedge clk) begin
        if (take && room) begin
            buf_mem[fill_q[AW-1:0]] <= rx_data;
        end
    end

    // Fill counter, published count and host read pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_q    <= '0;
            rd_q      <= '0;
            count_q   <= '0;
            receiving <= 1'b0;
        end else begin
            if (take) begin
                if (rx_last) begin
                    count_q   <= fill_next;
                    fill_q    <= '0;
                    rd_q      <= '0;
                    receiving <= 1'b0;
                end else begin
                    fill_q    <= fill_next;
                    receiving <= 1'b1;
                end
            end
            if (rd_pop && count_q != '0) begin
                rd_q    <= rd_q + ONE_C;
                count_q <= count_q - ONE_C;
            end
        end
    end

    // A host read with data left lowers the count by exactly one.
    assert_pop_dec_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_pop && count_q != '0) |=> (count_q == $past(count_q) - ONE_C));

    // A finished frame always publishes a nonzero count.
    assert_frame_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (count_q != '0));

endmodule

// File: rtl/pp_irq.sv
// Interrupt control: transmit-done and receive-ready flags cleared by
// writing 1, plus a test source armed by bit 31, whose visible bit clears
// on read and whose pending state clears on an all-zero write.
module pp_irq (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tx_done,
    input  logic        rx_done,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [31:0] wdata,
    output logic [31:0] ctl_word,
    output logic        rx_flag,
    output logic        irq
);
    import pp_pkg::*;

    logic tx_flag;
    logic test_bit;
    logic test_pend;

    // Register view and the level output.
    always_comb begin
        ctl_word              = '0;
        ctl_word[ICTL_TXDONE] = tx_flag;
        ctl_word[ICTL_RXRDY]  = rx_flag;
        ctl_word[ICTL_TEST]   = test_bit;
        irq                   = tx_flag || rx_flag || test_pend;
    end

    // Done flags: a new event wins over a simultaneous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_flag <= 1'b0;
            rx_flag <= 1'b0;
        end else begin
            if (tx_done)                           tx_flag <= 1'b1;
            else if (wr_en && wdata[ICTL_TXDONE])  tx_flag <= 1'b0;
            if (rx_done)                           rx_flag <= 1'b1;
            else if (wr_en && wdata[ICTL_RXRDY])   rx_flag <= 1'b0;
        end
    end

    // Test source: arm on bit 31, hide on read, remove on a zero write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            test_bit  <= 1'b0;
            test_pend <= 1'b0;
        end else if (wr_en) begin
            if (wdata[ICTL_TEST]) begin
                test_bit  <= 1'b1;
                test_pend <= 1'b1;
            end else if (wdata == '0) begin
                test_bit  <= 1'b0;
                test_pend <= 1'b0;
            end
        end else if (rd_en) begin
            test_bit <= 1'b0;
        end
    end

    // A read hides bit 31 on the next cycle.
    assert_test_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en) |=> !test_bit);

    // The level only falls through a register write.
    assert_irq_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !wr_en) |=> irq);

    // Transmit completion is always recorded.
    assert_txdone_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |=> tx_flag);

endmodule

// File: rtl/pkt_port.sv
// Top: register window decode for the byte-serial packet port. Reads are
// combinational in the access cycle; read side effects (receive pop,
// test bit hide) take place at the clock edge that ends the access.
module pkt_port #(
    parameter int          DEPTH     = 2048,
    parameter int          CNT_W     = 17,
    parameter logic [63:0] SIGNATURE = "PKTPORT1",
    parameter logic [31:0] ROUTE     = 32'd2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [5:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        tx_valid,
    input  logic        tx_ready,
    output logic [7:0]  tx_data,
    output logic        tx_last,
    input  logic        rx_valid,
    output logic        rx_ready,
    input  logic [7:0]  rx_data,
    input  logic        rx_last,
    output logic        irq
);
    import pp_pkg::*;

    localparam logic [63:0] ID_WORD = first_char_low(SIGNATURE);
    localparam int          PAD     = 32 - CNT_W;

    logic [5:0]       word_addr;
    logic             acc_wr;
    logic             acc_rd;
    logic [CNT_W-1:0] tx_len;
    logic [CNT_W-1:0] rx_cnt;
    logic [7:0]       rx_byte;
    logic             rx_busy;
    logic             tx_done;
    logic             rx_done;
    logic             rx_flag;
    logic [31:0]      ctl_word;

    // Access qualification and word-aligned address.
    always_comb begin
        word_addr = {bus_addr[5:2], 2'b00};
        acc_wr    = bus_sel && bus_wr;
        acc_rd    = bus_sel && !bus_wr;
    end

    pp_tx_path #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .len_we     (acc_wr && word_addr == OFS_TXCNT),
        .len_wdata  (bus_wdata[CNT_W-1:0]),
        .byte_we    (acc_wr && word_addr == OFS_TXDAT),
        .byte_wdata (bus_wdata[7:0]),
        .tx_ready   (tx_ready),
        .tx_valid   (tx_valid),
        .tx_data    (tx_data),
        .tx_last    (tx_last),
        .len_q      (tx_len),
        .done       (tx_done)
    );

    pp_rx_path #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .rx_last   (rx_last),
        .hold      (rx_flag),
        .rd_pop    (acc_rd && word_addr == OFS_RXDAT),
        .rx_ready  (rx_ready),
        .count_q   (rx_cnt),
        .rd_byte   (rx_byte),
        .receiving (rx_busy),
        .done      (rx_done)
    );

    pp_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_done  (tx_done),
        .rx_done  (rx_done),
        .wr_en    (acc_wr && word_addr == OFS_ICTL),
        .rd_en    (acc_rd && word_addr == OFS_ICTL),
        .wdata    (bus_wdata),
        .ctl_word (ctl_word),
        .rx_flag  (rx_flag),
        .irq      (irq)
    );

    // Read multiplexer over the register window.
    always_comb begin
        bus_rdata = '0;
        if (acc_rd) begin
            case (word_addr)
                OFS_ID_LO: bus_rdata = ID_WORD[31:0];
                OFS_ID_HI: bus_rdata = ID_WORD[63:32];
                OFS_BUSY:  bus_rdata = {31'd0, tx_valid || rx_busy};
                OFS_RXCNT: bus_rdata = {{PAD{1'b0}}, rx_cnt};
                OFS_TXCNT: bus_rdata = {{PAD{1'b0}}, tx_len};
                OFS_ICTL:  bus_rdata = ctl_word;
                OFS_ROUTE: bus_rdata = ROUTE;
                OFS_RXDAT: bus_rdata = {24'd0, rx_byte};
                default:   bus_rdata = '0;
            endcase
        end
    end

    // No byte is taken from the line while the receive flag is up.
    assert_rx_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_flag |-> !(rx_valid && rx_ready));

endmodule

// File: tb/sim_pkt_port.sv
`timescale 1ns/1ps
module sim_pkt_port;

    localparam int DEPTH = 16;
    localparam int CNT_W = 17;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tx_valid;
    logic        tx_ready = 1'b1;
    logic [7:0]  tx_data;
    logic        tx_last;
    logic        rx_valid = 1'b0;
    logic        rx_ready;
    logic [7:0]  rx_data = '0;
    logic        rx_last = 1'b0;
    logic        irq;

    int n_checks = 0;
    int n_fails  = 0;

    logic [7:0] cap_data [64];
    logic       cap_last [64];
    int         cap_n = 0;

    always #2 clk = ~clk;

    pkt_port #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .tx_last(tx_last), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .rx_data(rx_data), .rx_last(rx_last), .irq(irq)
    );

    // Record transmit handshakes; the handshake completes at the next edge.
    always @(negedge clk) begin
        if (rst_n && tx_valid && tx_ready && cap_n < 64) begin
            cap_data[cap_n] = tx_data;
            cap_last[cap_n] = tx_last;
            cap_n = cap_n + 1;
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        n_fails = n_fails + 1;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks = n_checks + 1;
        if (act !== exp) begin
            n_fails = n_fails + 1;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic rx_byte(input logic [7:0] d, input logic l);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = d; rx_last = l;
        while (!rx_ready) @(negedge clk);
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0;
    endtask

    task automatic set_ready(input logic v);
        @(posedge clk);
        #1 tx_ready = v;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        @(negedge clk);
        chk("R10 reset irq", {31'd0, irq}, 32'd0);
        chk("R2 reset tx_valid", {31'd0, tx_valid}, 32'd0);
        chk("R7 reset rx_ready", {31'd0, rx_ready}, 32'd1);
        bus_read(6'h0C, v); chk("R5 reset rx count", v, 32'd0);
        bus_read(6'h10, v); chk("R2 reset tx count", v, 32'd0);
        bus_read(6'h14, v); chk("R8 reset ictl", v, 32'd0);
        bus_read(6'h08, v); chk("R11 reset busy", v, 32'd0);
    endtask

    task automatic t_ident;
        logic [31:0] v;
        bus_read(6'h00, v); chk("R1 id low", v, 32'h50544B50);
        bus_read(6'h04, v); chk("R1 id high", v, 32'h3154524F);
        bus_read(6'h18, v); chk("R1 route", v, 32'd2);
        bus_write(6'h00, 32'hFFFF_FFFF);
        bus_write(6'h18, 32'h0000_00FF);
        bus_write(6'h0C, 32'd7);
        bus_write(6'h08, 32'd1);
        bus_read(6'h00, v); chk("R1 id low after write", v, 32'h50544B50);
        bus_read(6'h18, v); chk("R1 route after write", v, 32'd2);
        bus_read(6'h0C, v); chk("R1 rx count after write", v, 32'd0);
        bus_read(6'h08, v); chk("R1 busy after write", v, 32'd0);
    endtask

    task automatic t_tx_basic;
        logic [31:0] v;
        cap_n = 0;
        bus_write(6'h10, 32'd5);
        bus_read(6'h10, v); chk("R2 tx count readback", v, 32'd5);
        for (int i = 0; i < 5; i++) bus_write(6'h20, 32'hABCD_0010 + 32'(i));
        repeat (10) @(negedge clk);
        chk("R2 tx byte total", 32'(cap_n), 32'd5);
        for (int i = 0; i < 5; i++) begin
            chk("R2 tx byte", {24'd0, cap_data[i]}, 32'h10 + 32'(i));
            chk("R2 tx last", {31'd0, cap_last[i]}, {31'd0, (i == 4)});
        end
        bus_read(6'h10, v); chk("R3 tx count cleared", v, 32'd0);
        bus_read(6'h14, v); chk("R3 tx done bit", v, 32'h1);
        chk("R10 irq on tx done", {31'd0, irq}, 32'd1);
        bus_write(6'h14, 32'h0);
        bus_read(6'h14, v); chk("R8 zero write keeps bit0", v, 32'h1);
        bus_write(6'h14, 32'h1);
        bus_read(6'h14, v); chk("R8 w1c bit0", v, 32'h0);
        @(negedge clk); chk("R10 irq low after clear", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_tx_stall;
        logic [31:0] v;
        cap_n = 0;
        set_ready(1'b0);
        bus_write(6'h10, 32'd3);
        bus_write(6'h20, 32'h71);
        bus_write(6'h20, 32'h72);
        bus_write(6'h20, 32'h73);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R4 stall valid", {31'd0, tx_valid}, 32'd1);
            chk("R4 stall data", {24'd0, tx_data}, 32'h71);
            chk("R4 stall last", {31'd0, tx_last}, 32'd0);
        end
        bus_read(6'h08, v); chk("R11 busy while sending", v, 32'd1);
        bus_write(6'h20, 32'hEE);
        bus_write(6'h10, 32'd9);
        bus_read(6'h10, v); chk("R2 count write ignored while sending", v, 32'd3);
        set_ready(1'b1);
        repeat (8) @(negedge clk);
        chk("R2 stalled frame length", 32'(cap_n), 32'd3);
        chk("R4 stalled byte 0", {24'd0, cap_data[0]}, 32'h71);
        chk("R4 stalled byte 1", {24'd0, cap_data[1]}, 32'h72);
        chk("R2 payload write ignored while sending", {24'd0, cap_data[2]}, 32'h73);
        bus_read(6'h08, v); chk("R11 busy idle", v, 32'd0);
        bus_write(6'h14, 32'h1);
    endtask

    task automatic t_tx_clamp;
        logic [31:0] v;
        cap_n = 0;
        bus_write(6'h10, 32'd40);
        bus_read(6'h10, v); chk("R12 tx count clamped", v, 32'(DEPTH));
        for (int i = 0; i < DEPTH; i++) bus_write(6'h20, 32'(8'h80 + i));
        repeat (DEPTH + 6) @(negedge clk);
        chk("R12 clamped frame length", 32'(cap_n), 32'(DEPTH));
        chk("R12 clamped final byte", {24'd0, cap_data[DEPTH-1]}, 32'(8'h80 + DEPTH - 1));
        chk("R12 clamped final last", {31'd0, cap_last[DEPTH-1]}, 32'd1);
        bus_write(6'h14, 32'h1);
    endtask

    task automatic t_rx_basic;
        logic [31:0] v;
        for (int i = 0; i < 4; i++) rx_byte(8'h30 + 8'(i), i == 3);
        bus_read(6'h0C, v); chk("R5 rx count loaded", v, 32'd4);
        bus_read(6'h14, v); chk("R5 rx ready bit", v, 32'h2);
        chk("R10 irq on rx", {31'd0, irq}, 32'd1);
        @(negedge clk); chk("R7 ready low with frame pending", {31'd0, rx_ready}, 32'd0);
        for (int i = 0; i < 4; i++) begin
            bus_read(6'h1C, v); chk("R6 rx byte", v, 32'h30 + 32'(i));
            bus_read(6'h0C, v); chk("R6 rx count decrement", v, 32'(3 - i));
        end
        bus_read(6'h1C, v); chk("R6 read at zero", v, 32'd0);
        bus_read(6'h0C, v); chk("R6 count stays zero", v, 32'd0);
        @(negedge clk); chk("R7 ready low while bit1 set", {31'd0, rx_ready}, 32'd0);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = 8'h99; rx_last = 1'b1;
        repeat (3) @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0;
        bus_read(6'h0C, v); chk("R7 blocked byte not taken", v, 32'd0);
        bus_write(6'h14, 32'h2);
        bus_read(6'h14, v); chk("R8 w1c bit1", v, 32'h0);
        @(negedge clk);
        chk("R7 ready after acknowledge", {31'd0, rx_ready}, 32'd1);
        chk("R10 irq low after rx clear", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_rx_count_block;
        logic [31:0] v;
        rx_byte(8'h41, 1'b0);
        bus_read(6'h08, v); chk("R11 busy mid-frame", v, 32'd1);
        rx_byte(8'h42, 1'b1);
        bus_read(6'h08, v); chk("R11 busy after frame end", v, 32'd0);
        bus_write(6'h14, 32'h2);
        @(negedge clk); chk("R7 ready low while count nonzero", {31'd0, rx_ready}, 32'd0);
        bus_read(6'h1C, v); chk("R6 early-ack byte 0", v, 32'h41);
        bus_read(6'h1C, v); chk("R6 early-ack byte 1", v, 32'h42);
        @(negedge clk); chk("R7 ready once drained", {31'd0, rx_ready}, 32'd1);
    endtask

    task automatic t_rx_trunc;
        logic [31:0] v;
        for (int i = 0; i < DEPTH + 4; i++) rx_byte(8'(8'h50 + i), i == DEPTH + 3);
        bus_read(6'h0C, v); chk("R12 rx count truncated", v, 32'(DEPTH));
        for (int i = 0; i < DEPTH; i++) begin
            bus_read(6'h1C, v); chk("R12 truncated byte", v, 32'(8'(8'h50 + i)));
        end
        bus_read(6'h0C, v); chk("R12 truncated drained", v, 32'd0);
        bus_write(6'h14, 32'h2);
    endtask

    task automatic t_test_irq;
        logic [31:0] v;
        bus_write(6'h14, 32'h8000_0000);
        @(negedge clk); chk("R9 test raises irq", {31'd0, irq}, 32'd1);
        bus_read(6'h14, v); chk("R9 bit31 reads set", v, 32'h8000_0000);
        bus_read(6'h14, v); chk("R9 bit31 cleared by read", v, 32'h0);
        @(negedge clk); chk("R9 irq held after read", {31'd0, irq}, 32'd1);
        bus_write(6'h14, 32'h0);
        @(negedge clk); chk("R9 zero write removes test", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_or_sources;
        logic [31:0] v;
        rx_byte(8'h11, 1'b1);
        bus_write(6'h10, 32'd1);
        bus_write(6'h20, 32'h22);
        repeat (4) @(negedge clk);
        bus_read(6'h14, v); chk("R10 both flags", v, 32'h3);
        bus_write(6'h14, 32'h1);
        @(negedge clk); chk("R10 irq held by rx flag", {31'd0, irq}, 32'd1);
        bus_write(6'h14, 32'h2);
        @(negedge clk); chk("R10 irq low with no source", {31'd0, irq}, 32'd0);
        bus_read(6'h1C, v); chk("R6 single byte frame", v, 32'h11);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_ident;
        t_tx_basic;
        t_tx_stall;
        t_tx_clamp;
        t_rx_basic;
        t_rx_count_block;
        t_rx_trunc;
        t_test_irq;
        t_or_sources;
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule